// File: doc/BRIEF.md
# Signed Window Range Comparator

This peripheral holds two window bounds and one test value in 16-bit registers that are written over a simple strobed bus. It classifies the test value against the window the two bounds span and returns a three-valued code, so software can learn in one read whether a value lies inside the window, above it or below it.

The classification is not a plain signed window test. Which bound is the lower one is found by an unsigned comparison. The sign bits of the bounds then choose among several rule sets, and two degenerate bound pairs, both zero and both 0x8000, have rules of their own that take priority over the rest. The result is combinational from the stored registers, so it can be read in the cycle after the last write.

Top module: `wcmp_top`

## Requirements
- R1: The value on `rd_data` is always one of three codes: 0x0000 (inside), 0x4000 (above) or 0x8000 (below). It does not depend on `bus_addr`.
- R2: When both bounds are 0x0000, the code is 0x0000 for a test value of 0, 0x4000 for a test value from 0x0001 to 0x7FFF, and 0x8000 for a test value of 0x8000 or more. This rule is checked first.
- R3: When both bounds are 0x8000, the code is 0x0000 for a test value of 0x8000 and 0x4000 for any other test value. This rule is checked second.
- R4: In all other cases, let LO and HI be the smaller and larger bound under unsigned comparison. When both bounds are at most 0x7FFF, a test value of 0x8000 or more gives 0x8000. Otherwise a value below LO gives 0x8000, a value above HI gives 0x4000, and a value from LO to HI gives 0x0000.
- R5: When both bounds are 0x8000 or more, a test value of 0x7FFF or less gives 0x4000. Otherwise a value below LO gives 0x8000, a value above HI gives 0x4000, and a value from LO to HI gives 0x0000.
- R6: When exactly one bound has bit 15 set, a test value at or below LO, or at or above HI, gives 0x0000. A value above LO and no more than 0x7FFF gives 0x4000. A value from 0x8000 up to but not including HI gives 0x8000.
- R7: A clock edge with `wr_en` high loads `wr_data` into the first bound at byte offset 0, into the second bound at offset 2, or into the test value at offset 4. The new code appears on `rd_data` after that edge.
- R8: A write to offset 1, 3, 5, 6 or 7, and any cycle with `wr_en` low, leaves all three registers unchanged.
- R9: After reset, all three registers are zero and `rd_data` reads 0x0000.
- R10: Swapping the values of the two bounds does not change the code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| wr_en | input | 1 | Write strobe |
| bus_addr | input | 3 | Byte offset of the write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Classification code of the test value |

## Verification
The only state is the three registers, so a wrong register is seen at `rd_data` in the cycle after the write that should have set it. This holds only when the test value falls on the side of the window that the corrupted bound moves. For that reason the bench repeats each probe of an ignored offset with test values that would change the code whichever register was hit by mistake. A wrong rule in the classifier shows at once for the inputs it covers. The bench compares `rd_data` with its own behavioural model on every clock, covering both degenerate bound pairs, every sign combination, values exactly on LO and HI, and swapped bound pairs.

// File: rtl/wcmp_pkg.sv
package wcmp_pkg;

  // Register slots held by the bank
  typedef enum logic [1:0] {
    SLOT_LOW_BOUND  = 2'd0,
    SLOT_HIGH_BOUND = 2'd1,
    SLOT_PROBE      = 2'd2
  } slot_e;

  localparam int NUM_SLOTS = 3;

endpackage

// File: rtl/wcmp_regs.sv
module wcmp_regs
  import wcmp_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] bound_a,
  output logic [DW-1:0] bound_b,
  output logic [DW-1:0] probe_c
);

  localparam int STRIDE = DW / 8;

  logic [DW-1:0] slot_q [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic          hit;
    logic          load_en;
    logic [DW-1:0] slot_d;

    assign hit     = (bus_addr == AW'(i * STRIDE));
    assign load_en = wr_en && hit;

    always_comb begin
      slot_d = slot_q[i];
      if (load_en) slot_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[i] <= '0;
      else        slot_q[i] <= slot_d;
    end
  end

  assign bound_a = slot_q[SLOT_LOW_BOUND];
  assign bound_b = slot_q[SLOT_HIGH_BOUND];
  assign probe_c = slot_q[SLOT_PROBE];

  // R7: a strobed write to offset 0 lands in the first bound
  a_r7_load_first: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == AW'(0)) |=> (bound_a == $past(wr_data)));

  // R7: a strobed write to offset 4 lands in the test value
  a_r7_load_probe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == AW'(2 * STRIDE)) |=> (probe_c == $past(wr_data)));

  // R8: no strobe, no change
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(bound_a) && $stable(bound_b) && $stable(probe_c)));

  // R8: unmapped offsets leave every register alone
  a_r8_unmapped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr != AW'(0) && bus_addr != AW'(STRIDE) &&
     bus_addr != AW'(2 * STRIDE))
    |=> ($stable(bound_a) && $stable(bound_b) && $stable(probe_c)));

endmodule

// File: rtl/wcmp_classify.sv
module wcmp_classify #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] bound_a,
  input  logic [DW-1:0] bound_b,
  input  logic [DW-1:0] probe_c,
  output logic [DW-1:0] code
);

  localparam logic [DW-1:0] CODE_INSIDE = '0;
  localparam logic [DW-1:0] CODE_ABOVE  = {2'b01, {(DW-2){1'b0}}};
  localparam logic [DW-1:0] CODE_BELOW  = {2'b10, {(DW-2){1'b0}}};
  localparam logic [DW-1:0] SIGN_ONLY   = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] lo, hi;
  logic          a_neg, b_neg, c_neg;
  logic          both_zero, both_sign;
  logic          c_under, c_over;

  always_comb begin
    lo        = (bound_a < bound_b) ? bound_a : bound_b;
    hi        = (bound_a < bound_b) ? bound_b : bound_a;
    a_neg     = bound_a[DW-1];
    b_neg     = bound_b[DW-1];
    c_neg     = probe_c[DW-1];
    both_zero = (bound_a == '0) && (bound_b == '0);
    both_sign = (bound_a == SIGN_ONLY) && (bound_b == SIGN_ONLY);
    c_under   = probe_c < lo;
    c_over    = probe_c > hi;
  end

  always_comb begin
    code = CODE_INSIDE;
    if (both_zero) begin
      if (probe_c == '0) code = CODE_INSIDE;
      else if (!c_neg)   code = CODE_ABOVE;
      else               code = CODE_BELOW;
    end else if (both_sign) begin
      if (probe_c == SIGN_ONLY) code = CODE_INSIDE;
      else                      code = CODE_ABOVE;
    end else if (!a_neg && !b_neg) begin
      if (c_neg)        code = CODE_BELOW;
      else if (c_under) code = CODE_BELOW;
      else if (c_over)  code = CODE_ABOVE;
      else              code = CODE_INSIDE;
    end else if (a_neg && b_neg) begin
      if (!c_neg)       code = CODE_ABOVE;
      else if (c_under) code = CODE_BELOW;
      else if (c_over)  code = CODE_ABOVE;
      else              code = CODE_INSIDE;
    end else begin
      if (probe_c <= lo || probe_c >= hi) code = CODE_INSIDE;
      else if (!c_neg)                    code = CODE_ABOVE;
      else                                code = CODE_BELOW;
    end
  end

endmodule

// File: rtl/wcmp_top.sv
module wcmp_top #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);

  localparam logic [DW-1:0] SIGN_ONLY = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] ABOVE_V   = {2'b01, {(DW-2){1'b0}}};
  localparam logic [DW-1:0] BELOW_V   = {2'b10, {(DW-2){1'b0}}};

  // Asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [DW-1:0] bound_a, bound_b, probe_c, code;

  wcmp_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .wr_en    (wr_en),
    .bus_addr (bus_addr),
    .wr_data  (wr_data),
    .bound_a  (bound_a),
    .bound_b  (bound_b),
    .probe_c  (probe_c)
  );

  wcmp_classify #(.DW(DW)) u_cls (
    .bound_a (bound_a),
    .bound_b (bound_b),
    .probe_c (probe_c),
    .code    (code)
  );

  assign rd_data = code;

  // R1: only the three legal codes ever appear
  a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (rd_data == '0 || rd_data == ABOVE_V || rd_data == BELOW_V));

  // R2: zero bounds and zero probe read as inside
  a_r2_zero_window: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (bound_a == '0 && bound_b == '0 && probe_c == '0) |-> (rd_data == '0));

  // R3: sign-only bounds put every other probe above
  a_r3_sign_window: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (bound_a == SIGN_ONLY && bound_b == SIGN_ONLY && probe_c != SIGN_ONLY)
    |-> (rd_data == ABOVE_V));

  // R4: non-negative bounds, not both zero, negative probe reads below
  a_r4_neg_probe: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!bound_a[DW-1] && !bound_b[DW-1] && (bound_a != '0 || bound_b != '0) &&
     probe_c[DW-1]) |-> (rd_data == BELOW_V));

  // R5: negative bounds, not both sign-only, non-negative probe reads above
  a_r5_pos_probe: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (bound_a[DW-1] && bound_b[DW-1] &&
     (bound_a != SIGN_ONLY || bound_b != SIGN_ONLY) && !probe_c[DW-1])
    |-> (rd_data == ABOVE_V));

  // R6: mixed-sign bounds, probe equal to a bound reads inside
  a_r6_edge_inside: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ((bound_a[DW-1] != bound_b[DW-1]) &&
     (probe_c == bound_a || probe_c == bound_b)) |-> (rd_data == '0));

endmodule

// File: tb/wcmp_top_tb_top.sv
`timescale 1ns/1ps
module wcmp_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  bus_addr;
  logic [15:0] wr_data;
  logic [15:0] rd_data;

  int n_total = 0;
  int n_fail  = 0;
  bit cmp_on  = 0;
  bit done    = 0;
  string phase = "R9";

  logic [15:0] m_a, m_b, m_c;
  logic [31:0] rng = 32'h1ACE_B00C;

  always #2 clk = ~clk;

  wcmp_top dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .bus_addr (bus_addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data)
  );

  // Behavioural reference, built from the requirement text
  function automatic logic [15:0] expect_code(int unsigned a, int unsigned b, int unsigned c);
    int unsigned lo = (a < b) ? a : b;
    int unsigned hi = (a < b) ? b : a;
    if (a == 0 && b == 0) begin
      if (c == 0) return 16'h0000;
      return (c < 32768) ? 16'h4000 : 16'h8000;
    end
    if (a == 32768 && b == 32768) return (c == 32768) ? 16'h0000 : 16'h4000;
    if (a < 32768 && b < 32768) begin
      if (c >= 32768) return 16'h8000;
      if (c < lo) return 16'h8000;
      if (c > hi) return 16'h4000;
      return 16'h0000;
    end
    if (a >= 32768 && b >= 32768) begin
      if (c < 32768) return 16'h4000;
      if (c < lo) return 16'h8000;
      if (c > hi) return 16'h4000;
      return 16'h0000;
    end
    if (c <= lo || c >= hi) return 16'h0000;
    if (c < 32768) return 16'h4000;
    return 16'h8000;
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_total++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=%h expected=%h (a=%h b=%h c=%h)", req, got, exp, m_a, m_b, m_c);
    end
  endtask

  // Model registers: only the three mapped offsets load
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a <= 16'h0; m_b <= 16'h0; m_c <= 16'h0;
    end else if (wr_en) begin
      case (bus_addr)
        3'd0: m_a <= wr_data;
        3'd2: m_b <= wr_data;
        3'd4: m_c <= wr_data;
        default: ;
      endcase
    end
  end

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_on) check(phase, rd_data, expect_code(m_a, m_b, m_c));
  end

  task automatic wr(logic [2:0] ofs, logic [15:0] d);
    wr_en = 1'b1; bus_addr = ofs; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; bus_addr = 3'($urandom_range(0, 7));
  endtask

  task automatic probe(string req, logic [15:0] a, logic [15:0] b, logic [15:0] c);
    phase = req;
    wr(3'd0, a); wr(3'd2, b); wr(3'd4, c);
    check(req, rd_data, expect_code(a, b, c));
  endtask

  function automatic logic [15:0] next_val();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    case (rng[3:0])
      4'd0: return 16'h0000;
      4'd1: return 16'h8000;
      4'd2: return 16'h7FFF;
      4'd3: return 16'hFFFF;
      default: return rng[31:16];
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; bus_addr = 3'd0; wr_data = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset state reads inside
    check("R9", rd_data, 16'h0000);
    cmp_on = 1;

    // R2: both bounds zero
    probe("R2", 16'h0000, 16'h0000, 16'h0000);
    probe("R2", 16'h0000, 16'h0000, 16'h0001);
    probe("R2", 16'h0000, 16'h0000, 16'h7FFF);
    probe("R2", 16'h0000, 16'h0000, 16'h8000);
    probe("R2", 16'h0000, 16'h0000, 16'hFFFF);
    // R3: both bounds 0x8000
    probe("R3", 16'h8000, 16'h8000, 16'h8000);
    probe("R3", 16'h8000, 16'h8000, 16'h0000);
    probe("R3", 16'h8000, 16'h8000, 16'h1234);
    probe("R3", 16'h8000, 16'h8000, 16'hFFFF);
    // R4: non-negative bounds
    probe("R4", 16'h0100, 16'h0200, 16'h00FF);
    probe("R4", 16'h0100, 16'h0200, 16'h0100);
    probe("R4", 16'h0100, 16'h0200, 16'h0200);
    probe("R4", 16'h0100, 16'h0200, 16'h0201);
    probe("R4", 16'h0100, 16'h0200, 16'h9000);
    probe("R4", 16'h0000, 16'h0005, 16'h0000);
    // R5: negative bounds
    probe("R5", 16'hA000, 16'hC000, 16'h9FFF);
    probe("R5", 16'hA000, 16'hC000, 16'hA000);
    probe("R5", 16'hA000, 16'hC000, 16'hC000);
    probe("R5", 16'hA000, 16'hC000, 16'hC001);
    probe("R5", 16'hA000, 16'hC000, 16'h0010);
    probe("R5", 16'h8000, 16'h8004, 16'h8000);
    // R6: mixed signs
    probe("R6", 16'h0100, 16'hF000, 16'h0100);
    probe("R6", 16'h0100, 16'hF000, 16'h00FF);
    probe("R6", 16'h0100, 16'hF000, 16'h0101);
    probe("R6", 16'h0100, 16'hF000, 16'h7FFF);
    probe("R6", 16'h0100, 16'hF000, 16'h8000);
    probe("R6", 16'h0100, 16'hF000, 16'hEFFF);
    probe("R6", 16'h0100, 16'hF000, 16'hF000);
    probe("R6", 16'h0100, 16'hF000, 16'hFFFF);
    // R10: swapped bounds give the same code
    probe("R10", 16'hF000, 16'h0100, 16'h4000);
    check("R10", rd_data, 16'h4000);
    probe("R10", 16'h0200, 16'h0100, 16'h0150);
    check("R10", rd_data, 16'h0000);

    // R7: value is visible the cycle after its write
    phase = "R7";
    wr(3'd0, 16'h0100); wr(3'd2, 16'h0200); wr(3'd4, 16'h0150);
    check("R7", rd_data, 16'h0000);
    wr(3'd4, 16'h0300);
    check("R7", rd_data, 16'h4000);

    // R8: unmapped offsets and idle strobe change nothing
    phase = "R8";
    wr(3'd4, 16'h0150);
    for (int k = 0; k < 5; k++) begin
      logic [2:0] bad;
      case (k)
        0: bad = 3'd1; 1: bad = 3'd3; 2: bad = 3'd5; 3: bad = 3'd6; default: bad = 3'd7;
      endcase
      wr(bad, 16'h0160); check("R8", rd_data, 16'h0000);
      wr(bad, 16'h0140); check("R8", rd_data, 16'h0000);
      wr(bad, 16'h0050); check("R8", rd_data, 16'h0000);
    end
    for (int k = 0; k < 8; k++) begin
      bus_addr = 3'(k); wr_data = 16'h0050; wr_en = 1'b0;
      @(negedge clk);
      check("R8", rd_data, 16'h0000);
    end

    // R1, R10: pseudo-random triples and their swapped twins
    for (int k = 0; k < 400; k++) begin
      logic [15:0] a, b, c, first;
      a = next_val(); b = next_val(); c = next_val();
      probe("R1", a, b, c);
      first = rd_data;
      check("R1", (first == 16'h0000 || first == 16'h4000 || first == 16'h8000) ? 16'h0 : first, 16'h0);
      probe("R10", b, a, c);
      check("R10", rd_data, first);
    end

    cmp_on = 0;
    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule